// File: doc/BRIEF.md
# Accelerometer Self-Test Delta Sequencer

This block runs the electromechanical self-test of a three-axis accelerometer without software having to pace it. After a single start pulse it lets the sensor settle, averages a block of samples per axis with the self-test force off, turns the force on by a write to the sensor's format register, settles again and averages a second block. It then writes the format register back to its normal value and forms, per axis, the average with the force on minus the average with the force off.

Each difference is compared with a programmable signed lower and upper bound. The block presents the three differences and a pass flag per axis together with a one-cycle completion strobe. The register write port is shared with other masters, so a write is held until it is acknowledged. The sample stream comes from whatever transport reads the data registers. Samples that arrive outside an averaging window are dropped.

Top module: `accel_selftest_seq`

## Requirements
- R1: After reset `busy`, `done` and `wr_req` are low.
- R2: A `start` pulse while idle raises `busy` and begins a wait of SETTLE_CYC cycles. Samples offered during this wait, or during the wait that follows the self-test-on write, do not enter any average.
- R3: An averaging window takes exactly the next NSAMP (default 100) valid samples per axis. The average is the sum divided by NSAMP, truncated toward zero. Valid samples after the NSAMP-th one are ignored.
- R4: After the first window the block writes 0x8B to address 0x31. Bit 7 sets the self-test force and the low bits 0x0B keep the ±16 g 13-bit mode. `wr_req`, `wr_addr` and `wr_data` are held steady until `wr_ack` is seen high at a clock edge.
- R5: Once the self-test-on write has been acknowledged, a second wait of SETTLE_CYC cycles follows, then a second window of NSAMP samples.
- R6: After the second window the block writes 0x0B to address 0x31, clearing bit 7, before it reports any result.
- R7: For each axis, `delta` carries the self-test-on average minus the self-test-off average as a 17-bit two's-complement value. Axis x is in bits [16:0], y in [33:17] and z in [50:34]. Sample and limit slices use the same order in 16-bit fields: x in [15:0], y in [31:16], z in [47:32].
- R8: `axis_pass` bit k (bit 0 for x) is 1 exactly when the limit in `lim_lo` for that axis is at or below that axis's delta, and the delta is at or below the limit in `lim_hi`. The comparison is signed and both bounds are inclusive.
- R9: `done` is high for one cycle when the results become valid, and `busy` is low in the next cycle. `delta` and `axis_pass` then keep their values until the next completion.
- R10: A `start` pulse while `busy` is high is ignored. It neither restarts the sequence nor produces an extra completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a self-test run (honoured only while idle) |
| smp_valid | input | 1 | A sample is present on `smp_data` this cycle |
| smp_data | input | 48 | Three signed 16-bit samples, x in the low slice |
| wr_req | output | 1 | Register write request to the shared port |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Register data of the write |
| wr_ack | input | 1 | Shared port accepts the pending write |
| lim_lo | input | 48 | Three signed 16-bit lower limits |
| lim_hi | input | 48 | Three signed 16-bit upper limits |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe: results valid |
| delta | output | 51 | Three signed 17-bit deltas, x in the low slice |
| axis_pass | output | 3 | Per-axis limit result, x in bit 0 |

## Verification
A miscounted settle or window counter shows at the ports as a wrong delta at the next `done`. Samples deliberately offered during the settle waits and right after each window push such an error far away from the expected value. A wrong sign or rounding step in the divider shows as a delta off by one on axes with negative, non-integral averages. A broken sequencer shows as a missing or misordered write, or as a write that changes while unacknowledged, well before `done` is due. A sequencer that restarts on a stray start shows as a late or duplicated completion.

// File: rtl/st_seq_pkg.sv
package st_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SETTLE0, S_ACC0, S_DIV0, S_WR_ON,
    S_SETTLE1, S_ACC1, S_WR_OFF, S_DIV1, S_FIN
  } seq_state_t;

  // inclusive signed window test on sign-extended operands
  function automatic logic in_bounds(input logic signed [31:0] v,
                                     input logic signed [31:0] lo,
                                     input logic signed [31:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // magnitude of a sign-extended value
  function automatic logic [31:0] mag32(input logic signed [31:0] v);
    return v[31] ? 32'(-v) : 32'(v);
  endfunction

endpackage

// File: rtl/st_seq_acc.sv
module st_seq_acc #(
  parameter int NAXIS = 3,
  parameter int W     = 16,
  parameter int ACC_W = 24,
  parameter int NSAMP = 100,
  localparam int CNT_W = $clog2(NSAMP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic [NAXIS*W-1:0]     smp,
  output logic [NAXIS*ACC_W-1:0] sums,
  output logic [CNT_W-1:0]       taken,
  output logic                   full
);
  logic take;

  assign full = (taken == CNT_W'(NSAMP));
  assign take = en && !full;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) taken <= '0;
    else if (take)     taken <= taken + 1'b1;
  end

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    logic signed [ACC_W-1:0] sum_q;
    logic signed [W-1:0]     s_in;
    assign s_in = $signed(smp[a*W +: W]);
    always_ff @(posedge clk) begin
      if (!rst_n || clr) sum_q <= '0;
      else if (take)     sum_q <= sum_q + ACC_W'(s_in);
    end
    assign sums[a*ACC_W +: ACC_W] = sum_q;
  end

  // R3: once the window is full it stays full until cleared
  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr |=> full);

endmodule

// File: rtl/st_seq_div.sv
module st_seq_div #(
  parameter int ACC_W   = 24,
  parameter int DIVISOR = 100,
  localparam int CW = $clog2(ACC_W + 1),
  localparam int RW = $clog2(DIVISOR) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic signed [ACC_W-1:0] dividend,
  output logic signed [ACC_W-1:0] quo,
  output logic                    fin
);
  import st_seq_pkg::*;

  logic [ACC_W-1:0] shreg;
  logic [ACC_W-1:0] mag_q;
  logic [RW-1:0]    rem;
  logic [RW-1:0]    trial;
  logic [CW-1:0]    cnt;
  logic             neg, run, ge;

  assign trial = {rem[RW-2:0], shreg[ACC_W-1]};
  assign ge    = (trial >= RW'(DIVISOR));
  assign quo   = neg ? -$signed(shreg) : $signed(shreg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0; mag_q <= '0; rem <= '0; cnt <= '0;
      neg <= 1'b0; run <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        shreg <= dividend[ACC_W-1] ? ACC_W'(-dividend) : ACC_W'(dividend);
        mag_q <= dividend[ACC_W-1] ? ACC_W'(-dividend) : ACC_W'(dividend);
        neg   <= dividend[ACC_W-1];
        rem   <= '0;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        shreg <= {shreg[ACC_W-2:0], ge};
        rem   <= ge ? trial - RW'(DIVISOR) : trial;
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(ACC_W - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // R3: quotient magnitude is the floor of |dividend|/DIVISOR, sign follows dividend
  p_div_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (64'(mag32(32'(quo))) * DIVISOR <= 64'(mag_q)) &&
            (64'(mag_q) < (64'(mag32(32'(quo))) + 1) * DIVISOR));
  p_div_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin && (quo != '0) |-> (quo[ACC_W-1] == neg));

endmodule

// File: rtl/st_seq_lim.sv
module st_seq_lim #(
  parameter int NAXIS = 3,
  parameter int W     = 16,
  parameter int DW    = 17
) (
  input  logic [NAXIS*DW-1:0] d,
  input  logic [NAXIS*W-1:0]  lo,
  input  logic [NAXIS*W-1:0]  hi,
  output logic [NAXIS-1:0]    ok
);
  import st_seq_pkg::*;

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    logic signed [DW-1:0] dv;
    logic signed [W-1:0]  lv, hv;
    assign dv = $signed(d[a*DW +: DW]);
    assign lv = $signed(lo[a*W +: W]);
    assign hv = $signed(hi[a*W +: W]);
    assign ok[a] = in_bounds(32'(dv), 32'(lv), 32'(hv));
  end

endmodule

// File: rtl/accel_selftest_seq.sv
module accel_selftest_seq #(
  parameter int          NAXIS      = 3,
  parameter int          W          = 16,
  parameter int          NSAMP      = 100,
  parameter int          SETTLE_CYC = 110000,
  parameter logic [7:0]  CFG_ADDR   = 8'h31,
  parameter logic [7:0]  CFG_MODE   = 8'h0B,
  parameter int          ST_BIT     = 7,
  localparam int DW    = W + 1,
  localparam int ACC_W = (W + $clog2(NSAMP) + 1 > 24) ? W + $clog2(NSAMP) + 1 : 24,
  localparam int SW    = $clog2(SETTLE_CYC + 1),
  localparam int CNT_W = $clog2(NSAMP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                smp_valid,
  input  logic [NAXIS*W-1:0]  smp_data,
  output logic                wr_req,
  output logic [7:0]          wr_addr,
  output logic [7:0]          wr_data,
  input  logic                wr_ack,
  input  logic [NAXIS*W-1:0]  lim_lo,
  input  logic [NAXIS*W-1:0]  lim_hi,
  output logic                busy,
  output logic                done,
  output logic [NAXIS*DW-1:0] delta,
  output logic [NAXIS-1:0]    axis_pass
);
  import st_seq_pkg::*;

  localparam logic [7:0] CFG_ST = CFG_MODE | (8'h01 << ST_BIT);

  seq_state_t st, nxt;
  logic [SW-1:0]          scnt;
  logic                   in_settle, settle_end;
  logic                   acc_en, acc_full;
  logic [CNT_W-1:0]       acc_taken;
  logic [NAXIS*ACC_W-1:0] sums;
  logic                   div_go;
  logic [NAXIS-1:0]       div_fin;
  logic                   all_fin;
  logic [NAXIS*DW-1:0]    delta_nxt;
  logic [NAXIS-1:0]       pass_nxt;

  // named events
  assign in_settle  = (st == S_SETTLE0) || (st == S_SETTLE1);
  assign settle_end = in_settle && (scnt == SW'(SETTLE_CYC - 1));
  assign acc_en     = smp_valid && ((st == S_ACC0) || (st == S_ACC1));
  assign div_go     = ((st == S_ACC0) && acc_full) || ((st == S_WR_OFF) && wr_ack);
  assign all_fin    = &div_fin;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:    if (start)      nxt = S_SETTLE0;
      S_SETTLE0: if (settle_end) nxt = S_ACC0;
      S_ACC0:    if (acc_full)   nxt = S_DIV0;
      S_DIV0:    if (all_fin)    nxt = S_WR_ON;
      S_WR_ON:   if (wr_ack)     nxt = S_SETTLE1;
      S_SETTLE1: if (settle_end) nxt = S_ACC1;
      S_ACC1:    if (acc_full)   nxt = S_WR_OFF;
      S_WR_OFF:  if (wr_ack)     nxt = S_DIV1;
      S_DIV1:    if (all_fin)    nxt = S_FIN;
      S_FIN:                     nxt = S_IDLE;
      default:                   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      scnt <= '0;
    end else begin
      st   <= nxt;
      scnt <= in_settle ? scnt + 1'b1 : '0;
    end
  end

  assign wr_req  = (st == S_WR_ON) || (st == S_WR_OFF);
  assign wr_addr = wr_req ? CFG_ADDR : 8'h00;
  assign wr_data = (st == S_WR_ON) ? CFG_ST : ((st == S_WR_OFF) ? CFG_MODE : 8'h00);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);

  st_seq_acc #(.NAXIS(NAXIS), .W(W), .ACC_W(ACC_W), .NSAMP(NSAMP)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(settle_end), .en(acc_en),
    .smp(smp_data), .sums(sums), .taken(acc_taken), .full(acc_full)
  );

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    logic signed [ACC_W-1:0] quo;
    logic signed [ACC_W-1:0] avg_off;
    logic signed [ACC_W-1:0] diff;
    logic signed [DW-1:0]    delta_q;

    st_seq_div #(.ACC_W(ACC_W), .DIVISOR(NSAMP)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go),
      .dividend($signed(sums[a*ACC_W +: ACC_W])),
      .quo(quo), .fin(div_fin[a])
    );

    assign diff = quo - avg_off;
    assign delta_nxt[a*DW +: DW] = DW'(diff);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        avg_off <= '0;
        delta_q <= '0;
      end else begin
        if ((st == S_DIV0) && all_fin) avg_off <= quo;
        if ((st == S_DIV1) && all_fin) delta_q <= DW'(diff);
      end
    end
    assign delta[a*DW +: DW] = delta_q;
  end

  st_seq_lim #(.NAXIS(NAXIS), .W(W), .DW(DW)) u_lim (
    .d(delta_nxt), .lo(lim_lo), .hi(lim_hi), .ok(pass_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                         axis_pass <= '0;
    else if ((st == S_DIV1) && all_fin) axis_pass <= pass_nxt;
  end

  // R4: a pending write holds its request, address and data until acknowledged
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));
  // R2: samples during a settle wait do not advance the window count
  p_settle_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_settle && smp_valid |=> (acc_taken == $past(acc_taken)) || (acc_taken == '0));
  // R9: completion strobe is a single cycle and the block is idle after it
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R10: a start seen mid-run never re-enters the first settle wait
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && (st != S_IDLE) && (st != S_SETTLE0) |=> (st != S_SETTLE0));
  // R6: the restoring write happens before the result strobe
  p_off_before_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st) == S_DIV1);

endmodule

// File: tb/accel_selftest_seq_test.sv
module accel_selftest_seq_test;
  localparam int N  = 3;
  localparam int W  = 16;
  localparam int DW = 17;
  localparam int NS = 100;
  localparam int ST = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, start, smp_valid, wr_ack;
  logic [N*W-1:0]  smp_data, lim_lo, lim_hi;
  logic            wr_req, busy, done;
  logic [7:0]      wr_addr, wr_data;
  logic [N*DW-1:0] delta;
  logic [N-1:0]    axis_pass;

  accel_selftest_seq #(.SETTLE_CYC(ST)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
    .smp_data(smp_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .busy(busy), .done(done), .delta(delta), .axis_pass(axis_pass)
  );

  typedef struct { int d[N]; bit p[N]; } exp_t;
  exp_t expq[$];
  exp_t last_exp;
  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int smpv(input int base, input int i, input int ax);
    return base + ((i * 37 + ax * 11) % 23) - 11;
  endfunction

  function automatic int avg_of(input int base, input int ax);
    int s = 0;
    for (int i = 0; i < NS; i++) s += smpv(base, i, ax);
    return s / NS;  // integer division truncates toward zero
  endfunction

  function automatic int dsl(input int ax);
    return int'($signed(delta[ax*DW +: DW]));
  endfunction

  task automatic drive_junk(input int n, input bit poke);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = {16'sh7FF0, 16'sh8010, 16'sh7ABC};
      start     = poke && (k == 2);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    start     = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send_window(input int base[N], input bit gaps);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      for (int a = 0; a < N; a++) smp_data[a*W +: W] = W'(smpv(base[a], i, a));
      if (gaps && (i % 3 == 2)) begin
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        smp_valid = 1'b1;
        for (int a = 0; a < N; a++) smp_data[a*W +: W] = W'(smpv(base[a], i, a));
      end
    end
    drive_junk(3, 1'b0);  // R3: extra samples after the window
  endtask

  task automatic do_write(input logic [7:0] dexp, input string req);
    int t = 0;
    @(negedge clk);
    while (!wr_req && t < 1000) begin @(negedge clk); t++; end
    chk(wr_req && wr_addr == 8'h31, req, "write address", int'(wr_addr), 'h31);
    chk(wr_data == dexp, req, "write data", int'(wr_data), int'(dexp));
    idle(3);
    chk(wr_req && wr_data == dexp && wr_addr == 8'h31, "R4", "write held before ack",
        int'(wr_data), int'(dexp));
    wr_ack = 1'b1;
    @(negedge clk);
    wr_ack = 1'b0;
  endtask

  task automatic run_case(input int off[N], input int on[N], input int lo[N],
                          input int hi[N], input bit gaps, input bit poke);
    exp_t e;
    int t = 0;
    for (int a = 0; a < N; a++) begin
      e.d[a] = avg_of(on[a], a) - avg_of(off[a], a);
      e.p[a] = (lo[a] <= e.d[a]) && (e.d[a] <= hi[a]);
      lim_lo[a*W +: W] = W'(lo[a]);
      lim_hi[a*W +: W] = W'(hi[a]);
    end
    expq.push_back(e);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    drive_junk(ST - 6, 1'b0);   // R2: ignored during first settle
    idle(10);
    send_window(off, gaps);
    do_write(8'h8B, "R4");
    drive_junk(ST - 6, poke);   // R5: ignored during second settle; R10 poke
    idle(10);
    send_window(on, gaps);
    do_write(8'h0B, "R6");
    while (expq.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    chk(expq.size() == 0, "R9", "completion seen", expq.size(), 0);
    idle(ST + 60);              // R10: no second completion from the poke
    chk(busy == 1'b0, "R9", "idle after run", int'(busy), 0);
    for (int a = 0; a < N; a++)
      chk(dsl(a) == last_exp.d[a], "R9", "delta held", dsl(a), last_exp.d[a]);
  endtask

  // monitor: scoreboard pops expectations at each completion
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R10", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        last_exp = e;
        for (int a = 0; a < N; a++) begin
          chk(dsl(a) == e.d[a], "R7", $sformatf("delta axis %0d", a), dsl(a), e.d[a]);
          chk(axis_pass[a] == e.p[a], "R8", $sformatf("pass axis %0d", a),
              int'(axis_pass[a]), int'(e.p[a]));
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; smp_valid = 1'b0; wr_ack = 1'b0;
    smp_data = '0; lim_lo = '0; lim_hi = '0;
    fork
      begin
        int off[N], on[N], lo[N], hi[N], d[N];
        idle(4);
        chk(!busy && !done && !wr_req, "R1", "reset outputs",
            int'({busy, done, wr_req}), 0);
        rst_n = 1'b1;
        idle(2);
        chk(!busy && !done && !wr_req, "R1", "idle after reset",
            int'({busy, done, wr_req}), 0);
        // case 1: positive deltas inside wide limits
        off = '{100, -200, 300}; on = '{500, 150, 1200};
        lo = '{50, 50, 50}; hi = '{2000, 2000, 2000};
        run_case(off, on, lo, hi, 1'b0, 1'b0);
        // case 2: negative non-integral averages, exact-boundary limits, gaps, start poke
        off = '{-37, -5, 12}; on = '{-500, -1234, 9};
        for (int a = 0; a < N; a++) d[a] = avg_of(on[a], a) - avg_of(off[a], a);
        lo = '{d[0], d[1] + 1, -1000}; hi = '{d[0], 2000, d[2] - 1};
        run_case(off, on, lo, hi, 1'b1, 1'b1);
        // case 3: deltas beyond 16 bits, full-range limits
        off = '{-20000, 20000, 0}; on = '{20000, -20000, 0};
        lo = '{-32768, -32768, -32768}; hi = '{32767, 32767, 32767};
        run_case(off, on, lo, hi, 1'b0, 1'b0);
      end
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule